// File: doc/BRIEF.md
# Mesh Router Route-Compute Stage

This block is the route-compute step at the head of one input unit of a 2D-mesh router. When a header flit arrives, the block reads the flit's destination coordinates and the message class tied to the input virtual channel. It then returns the output port the packet must leave on, together with a mask of the output virtual channels that the packet may request.

The mask holds only the virtual channel reserved for the packet's message class. Because of this, a generic virtual-channel allocator further down the pipeline can never grant a channel that breaks class isolation. That isolation is what keeps protocol deadlock out of the network.

Routing is dimension-ordered. X is corrected first, then Y. The router's own coordinates come in as static strap inputs, so one netlist serves every tile. The result is registered and held in an output stage that accepts a ready signal from downstream.

Top module: `mesh_route_stage`

## Requirements
- R1: While reset is held, and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: If the destination x is below the router x, the port is 0, whatever the y values.
- R3: If the destination x is above the router x, the port is 1, whatever the y values.
- R4: If the x values are equal, the port is 2 when the destination y is below the router y, and 3 when it is above.
- R5: If both coordinates are equal to the router's own, the port is 4 (the local network interface).
- R6: For a class value c from 0 to 4, the mask is one-hot with only bit c set (class 0 CPU request, 1 CPU response, 2 accelerator request, 3 configuration/interrupt, 4 accelerator response), and `out_class_err` is 0.
- R7: A class value of 5 to 7 gives an all-zero mask and sets `out_class_err` to 1. The port is still computed as usual.
- R8: A header accepted at a clock edge (`in_valid` and `in_ready` both high) appears on the outputs with `out_valid` = 1 right after that edge.
- R9: While `out_valid` is 1 and `out_ready` is 0, the outputs hold their values and `in_ready` is 0.
- R10: `in_ready` is 1 whenever the output is empty or is being drained in the same cycle (`out_ready` = 1). When `out_valid` = 1 and `out_ready` = 1 with no new header, `out_valid` falls after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| here_x | input | 2 | X coordinate of this router (static) |
| here_y | input | 2 | Y coordinate of this router (static) |
| in_valid | input | 1 | A header is offered |
| in_ready | output | 1 | The stage can take a header |
| in_dst_x | input | 2 | Destination x from the header flit |
| in_dst_y | input | 2 | Destination y from the header flit |
| in_class | input | 3 | Message class of the input virtual channel |
| out_valid | output | 1 | A routing result is held |
| out_ready | input | 1 | Downstream takes the result |
| out_port | output | 3 | Output port: 0 -x, 1 +x, 2 -y, 3 +y, 4 local |
| out_vc_mask | output | 5 | Eligible output virtual channels |
| out_class_err | output | 1 | The class value is out of range |

## Verification
The bench builds the block with its default 4x4 mesh, five classes and five virtual channels. This size is small enough that every router position, every destination and every 3-bit class value can be swept: 2048 headers in all. Those sweeps cover every branch of the dimension-order decision and each out-of-range class code. A separate sequence holds off `out_ready`, so the output hold and the accept-while-draining case are exercised.

// File: rtl/mesh_route_pkg.sv
package mesh_route_pkg;

    localparam int PORT_W = 3;

    typedef enum logic [PORT_W-1:0] {
        PORT_XNEG  = 3'd0,
        PORT_XPOS  = 3'd1,
        PORT_YNEG  = 3'd2,
        PORT_YPOS  = 3'd3,
        PORT_LOCAL = 3'd4
    } port_e;

endpackage

// File: rtl/xy_route_calc.sv
module xy_route_calc
    import mesh_route_pkg::*;
#(
    parameter int XW = 2,
    parameter int YW = 2
) (
    input  logic [XW-1:0] cur_x,
    input  logic [YW-1:0] cur_y,
    input  logic [XW-1:0] dst_x,
    input  logic [YW-1:0] dst_y,
    output port_e         port
);
    // X is resolved before Y; the local port is chosen only on an exact match.
    always_comb begin
        if (dst_x < cur_x)      port = PORT_XNEG;
        else if (dst_x > cur_x) port = PORT_XPOS;
        else if (dst_y < cur_y) port = PORT_YNEG;
        else if (dst_y > cur_y) port = PORT_YPOS;
        else                    port = PORT_LOCAL;
    end
endmodule

// File: rtl/class_vc_map.sv
module class_vc_map #(
    parameter int NUM_CLASSES = 5,
    parameter int NUM_VC      = 5,
    parameter int CLS_W       = 3
) (
    input  logic [CLS_W-1:0]  cls,
    output logic [NUM_VC-1:0] vc_mask,
    output logic              cls_err
);
    localparam logic [CLS_W:0] CLS_LIMIT = (CLS_W+1)'(NUM_CLASSES);

    // Each class owns the virtual channel with the same index.
    for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
        if (v < NUM_CLASSES) begin : g_used
            assign vc_mask[v] = (cls == CLS_W'(v));
        end else begin : g_spare
            assign vc_mask[v] = 1'b0;
        end
    end

    assign cls_err = ({1'b0, cls} >= CLS_LIMIT);
endmodule

// File: rtl/mesh_route_stage.sv
module mesh_route_stage
    import mesh_route_pkg::*;
#(
    parameter int MESH_X      = 4,
    parameter int MESH_Y      = 4,
    parameter int NUM_CLASSES = 5,
    parameter int NUM_VC      = 5,
    parameter int CLS_W       = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [$clog2(MESH_X)-1:0]  here_x,
    input  logic [$clog2(MESH_Y)-1:0]  here_y,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [$clog2(MESH_X)-1:0]  in_dst_x,
    input  logic [$clog2(MESH_Y)-1:0]  in_dst_y,
    input  logic [CLS_W-1:0]           in_class,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [PORT_W-1:0]          out_port,
    output logic [NUM_VC-1:0]          out_vc_mask,
    output logic                       out_class_err
);
    localparam int XW = $clog2(MESH_X);
    localparam int YW = $clog2(MESH_Y);

    typedef struct packed {
        logic              valid;
        logic [PORT_W-1:0] port;
        logic [NUM_VC-1:0] mask;
        logic              err;
    } result_t;

    result_t           res_d, res_q;
    port_e             calc_port;
    logic [NUM_VC-1:0] calc_mask;
    logic              calc_err;

    xy_route_calc #(.XW(XW), .YW(YW)) u_route (
        .cur_x (here_x),
        .cur_y (here_y),
        .dst_x (in_dst_x),
        .dst_y (in_dst_y),
        .port  (calc_port)
    );

    class_vc_map #(
        .NUM_CLASSES (NUM_CLASSES),
        .NUM_VC      (NUM_VC),
        .CLS_W       (CLS_W)
    ) u_map (
        .cls     (in_class),
        .vc_mask (calc_mask),
        .cls_err (calc_err)
    );

    assign in_ready = !res_q.valid || out_ready;

    always_comb begin
        res_d = res_q;
        if (in_ready) begin
            res_d.valid = in_valid;
            if (in_valid) begin
                res_d.port = calc_port;
                res_d.mask = calc_mask;
                res_d.err  = calc_err;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid     = res_q.valid;
    assign out_port      = res_q.port;
    assign out_vc_mask   = res_q.mask;
    assign out_class_err = res_q.err;
endmodule

// File: rtl/mesh_route_checker.sv
module mesh_route_checker #(
    parameter int MESH_X      = 4,
    parameter int MESH_Y      = 4,
    parameter int NUM_VC      = 5,
    parameter int CLS_W       = 3
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [$clog2(MESH_X)-1:0] here_x,
    input logic [$clog2(MESH_Y)-1:0] here_y,
    input logic                      in_valid,
    input logic                      in_ready,
    input logic [$clog2(MESH_X)-1:0] in_dst_x,
    input logic [$clog2(MESH_Y)-1:0] in_dst_y,
    input logic [CLS_W-1:0]          in_class,
    input logic                      out_valid,
    input logic                      out_ready,
    input logic [2:0]                out_port,
    input logic [NUM_VC-1:0]         out_vc_mask,
    input logic                      out_class_err
);
    a_r2_xneg: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_dst_x < here_x) |=> (out_port == 3'd0));

    a_r3_xpos: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_dst_x > here_x) |=> (out_port == 3'd1));

    a_r5_local: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_dst_x == here_x && in_dst_y == here_y)
        |=> (out_port == 3'd4));

    a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_class_err) |-> ($countones(out_vc_mask) == 1));

    a_r7_err: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_class > 3'd4)
        |=> (out_class_err && out_vc_mask == '0));

    a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_port)
                                      && $stable(out_vc_mask) && $stable(out_class_err)));

    a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);
endmodule

bind mesh_route_stage mesh_route_checker #(
    .MESH_X (MESH_X),
    .MESH_Y (MESH_Y),
    .NUM_VC (NUM_VC),
    .CLS_W  (CLS_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .here_x        (here_x),
    .here_y        (here_y),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_dst_x      (in_dst_x),
    .in_dst_y      (in_dst_y),
    .in_class      (in_class),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_port      (out_port),
    .out_vc_mask   (out_vc_mask),
    .out_class_err (out_class_err)
);

// File: tb/tb_mesh_route_stage.sv
module tb_mesh_route_stage;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] here_x, here_y, in_dst_x, in_dst_y;
    logic       in_valid, in_ready, out_valid, out_ready, out_class_err;
    logic [2:0] in_class, out_port;
    logic [4:0] out_vc_mask;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mesh_route_stage dut (
        .clk(clk), .rst_n(rst_n), .here_x(here_x), .here_y(here_y),
        .in_valid(in_valid), .in_ready(in_ready), .in_dst_x(in_dst_x),
        .in_dst_y(in_dst_y), .in_class(in_class), .out_valid(out_valid),
        .out_ready(out_ready), .out_port(out_port), .out_vc_mask(out_vc_mask),
        .out_class_err(out_class_err)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_port(input int hx, input int hy, input int dx, input int dy);
        if (dx < hx) return 0;
        if (dx > hx) return 1;
        if (dy < hy) return 2;
        if (dy > hy) return 3;
        return 4;
    endfunction

    function automatic string port_req(input int p);
        case (p)
            0: return "R2";
            1: return "R3";
            2, 3: return "R4";
            default: return "R5";
        endcase
    endfunction

    initial begin
        int limit;
        limit = 100000;
        repeat (limit) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", limit, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
        here_x = 0; here_y = 0; in_dst_x = 0; in_dst_y = 0; in_class = 0;
        repeat (3) @(negedge clk);
        check("R1 out_valid in reset", int'(out_valid), 0);
        check("R1 in_ready in reset", int'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid after reset", int'(out_valid), 0);

        // Full sweep: router position, destination, class code
        for (int hx = 0; hx < 4; hx++)
        for (int hy = 0; hy < 4; hy++)
        for (int dx = 0; dx < 4; dx++)
        for (int dy = 0; dy < 4; dy++)
        for (int c = 0; c < 8; c++) begin
            int p;
            here_x = 2'(hx); here_y = 2'(hy);
            in_dst_x = 2'(dx); in_dst_y = 2'(dy); in_class = 3'(c);
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            p = exp_port(hx, hy, dx, dy);
            check("R8 valid after accept", int'(out_valid), 1);
            check(port_req(p), int'(out_port), p);
            if (c < 5) begin
                check("R6 mask", int'(out_vc_mask), 1 << c);
                check("R6 err", int'(out_class_err), 0);
            end else begin
                check("R7 mask", int'(out_vc_mask), 0);
                check("R7 err", int'(out_class_err), 1);
            end
        end
        @(negedge clk);
        check("R10 drained", int'(out_valid), 0);

        // Back-pressure sequence
        here_x = 2; here_y = 1;
        out_ready = 1'b0;
        in_dst_x = 0; in_dst_y = 3; in_class = 3'd1; in_valid = 1'b1;
        @(negedge clk);
        check("R8 held result valid", int'(out_valid), 1);
        check("R9 in_ready low", int'(in_ready), 0);
        in_dst_x = 3; in_dst_y = 0; in_class = 3'd4;
        repeat (2) @(negedge clk);
        check("R9 port held", int'(out_port), 0);
        check("R9 mask held", int'(out_vc_mask), 2);
        check("R9 still stalled", int'(in_ready), 0);
        out_ready = 1'b1;
        #1;
        check("R10 ready while draining", int'(in_ready), 1);
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 next header taken", int'(out_port), 1);
        check("R10 next mask", int'(out_vc_mask), 16);
        @(negedge clk);
        check("R10 empty after drain", int'(out_valid), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule